// File: doc/BRIEF.md
# Bank Activation and State Tracker

This block follows one DRAM bank on behalf of a memory controller. It records whether the bank is open or closed and which row is open. It keeps a saturating count of row activations since the last relief. A refresh scheduler reads that count to decide when refresh management must be issued.

Every accepted command arrives as a strobe with a code. Normal refreshes reduce the count by one programmable amount. Refresh-management commands reduce it by a second programmable amount. Neither reduction takes the count below zero, and both apply only while refresh management is enabled.

The block also keeps a blocked flag and a sleeping flag. The scheduler sets the blocked flag to stop new accesses. Power-down entry sets the sleeping flag. Any refresh-type command clears both flags. An idle indication passes through from the request queue.

Top module: `act_track_bank`

## Requirements
- R1: After reset, bank_open_o is 0, open_row_o is 0, act_count_o is 0, blocked_o is 0 and sleeping_o is 0.
- R2: A command with code 1 (activate) sets bank_open_o to 1, loads open_row_o from row_i and adds one to act_count_o, all visible after the next rising clock edge.
- R3: An activate received while act_count_o is at its maximum value (all ones) leaves it at all ones; the count never wraps.
- R4: Codes 2, 3 and 4 (single, all-bank and same-bank precharge) clear bank_open_o and leave open_row_o and act_count_o unchanged.
- R5: Codes 5 and 6 (all-bank and same-bank refresh) with rm_enable_i high set the count to count minus ref_dec_i when the count is greater than ref_dec_i, and to 0 otherwise.
- R6: Codes 7 and 8 (all-bank and same-bank refresh management) with rm_enable_i high set the count to count minus rm_dec_i when the count is greater than rm_dec_i, and to 0 otherwise.
- R7: With rm_enable_i low, codes 5 to 8 leave act_count_o unchanged.
- R8: Codes 5 to 8 clear blocked_o and sleeping_o.
- R9: block_i sets blocked_o and unblock_i clears it. When block_i coincides with unblock_i or with a clearing command, blocked_o ends up set.
- R10: Code 9 (power-down entry) sets sleeping_o. Code 10 (power-down exit) clears it.
- R11: idle_o is the inverse of req_pending_i in the same cycle.
- R12: When cmd_valid_i is low, or the code is 0 or 11 to 15, the command changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 4 | Command code |
| row_i | input | ROW_W | Row address for activate |
| rm_enable_i | input | 1 | Refresh-management enable |
| ref_dec_i | input | CNT_W | Count reduction on refresh |
| rm_dec_i | input | CNT_W | Count reduction on refresh management |
| block_i | input | 1 | Block request |
| unblock_i | input | 1 | Unblock request |
| req_pending_i | input | 1 | Request queue has work for this bank |
| bank_open_o | output | 1 | 1 when the bank is activated |
| open_row_o | output | ROW_W | Open row address |
| act_count_o | output | CNT_W | Rolling activation count |
| blocked_o | output | 1 | Bank blocked flag |
| sleeping_o | output | 1 | Bank sleeping flag |
| idle_o | output | 1 | No request pending |

## Verification
Two requests can meet in one cycle: a block request from the scheduler, and a refresh or refresh-management command that clears the flag. The bench drives block_i in the same cycle as codes 5 and 8. It also drives block_i together with unblock_i. In each case it expects blocked_o to stay set, because the set has priority. The saturation corner is reached by a long run of activates. The count must then hold at its maximum until a refresh-management command reduces it.

// File: rtl/act_track_pkg.sv
package act_track_pkg;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_ACT   = 4'd1,
    CMD_PRE   = 4'd2,
    CMD_PREA  = 4'd3,
    CMD_PRESB = 4'd4,
    CMD_REFAB = 4'd5,
    CMD_REFSB = 4'd6,
    CMD_RMAB  = 4'd7,
    CMD_RMSB  = 4'd8,
    CMD_PDE   = 4'd9,
    CMD_PDX   = 4'd10
  } cmd_e;

  typedef struct packed {
    logic act;
    logic pre;
    logic refr;
    logic rm;
    logic pde;
    logic pdx;
  } cmd_hit_t;

endpackage

// File: rtl/act_track_decode.sv
module act_track_decode
  import act_track_pkg::*;
(
  input  logic       valid_i,
  input  logic [3:0] code_i,
  output cmd_hit_t   hit_o
);

  always_comb begin
    hit_o = '0;
    if (valid_i) begin
      unique case (code_i)
        CMD_ACT:                      hit_o.act  = 1'b1;
        CMD_PRE, CMD_PREA, CMD_PRESB: hit_o.pre  = 1'b1;
        CMD_REFAB, CMD_REFSB:         hit_o.refr = 1'b1;
        CMD_RMAB, CMD_RMSB:           hit_o.rm   = 1'b1;
        CMD_PDE:                      hit_o.pde  = 1'b1;
        CMD_PDX:                      hit_o.pdx  = 1'b1;
        default:                      hit_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/act_track_counter.sv
module act_track_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             ref_i,
  input  logic             rm_i,
  input  logic             rm_en_i,
  input  logic [CNT_W-1:0] ref_dec_i,
  input  logic [CNT_W-1:0] rm_dec_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, amt;
  logic             dec_en;

  assign amt    = ref_i ? ref_dec_i : rm_dec_i;
  assign dec_en = rm_en_i & (ref_i | rm_i);

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i) begin
      if (cnt_q != CntMax) cnt_d = cnt_q + 1'b1;
    end else if (dec_en) begin
      cnt_d = (cnt_q > amt) ? cnt_q - amt : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q == CntMax) |=> (cnt_q == CntMax)); // R3
  AST_CNT_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_i && rm_en_i && cnt_q <= ref_dec_i) |=> (cnt_q == '0)); // R5
  AST_RM_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rm_i && rm_en_i && cnt_q <= rm_dec_i) |=> (cnt_q == '0)); // R6
  AST_CNT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !rm_en_i) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/act_track_state.sv
module act_track_state #(
  parameter int ROW_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o
);

  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (pre_i) begin
      open_q <= 1'b0;
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;

  AST_ACT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> (open_q && row_q == $past(row_i))); // R2
  AST_PRE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |=> (!open_q && $stable(row_q))); // R4

endmodule

// File: rtl/act_track_flags.sv
module act_track_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic block_i,
  input  logic unblock_i,
  input  logic pde_i,
  input  logic pdx_i,
  output logic blocked_o,
  output logic sleeping_o
);

  logic blk_q, slp_q;

  // set has priority over any clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   blk_q <= 1'b0;
    else if (block_i)              blk_q <= 1'b1;
    else if (clr_i || unblock_i)   blk_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   slp_q <= 1'b0;
    else if (clr_i || pdx_i)       slp_q <= 1'b0;
    else if (pde_i)                slp_q <= 1'b1;
  end

  assign blocked_o  = blk_q;
  assign sleeping_o = slp_q;

  AST_BLOCK_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_i |=> blk_q); // R9
  AST_CLR_UNBLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !block_i) |=> !blk_q); // R8
  AST_CLR_WAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !slp_q); // R8
  AST_PDE_SLEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pde_i |=> slp_q); // R10

endmodule

// File: rtl/act_track_bank.sv
module act_track_bank
  import act_track_pkg::*;
#(
  parameter int ROW_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [3:0]       cmd_code_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             rm_enable_i,
  input  logic [CNT_W-1:0] ref_dec_i,
  input  logic [CNT_W-1:0] rm_dec_i,
  input  logic             block_i,
  input  logic             unblock_i,
  input  logic             req_pending_i,
  output logic             bank_open_o,
  output logic [ROW_W-1:0] open_row_o,
  output logic [CNT_W-1:0] act_count_o,
  output logic             blocked_o,
  output logic             sleeping_o,
  output logic             idle_o
);

  cmd_hit_t hit;

  act_track_decode u_dec (
    .valid_i (cmd_valid_i),
    .code_i  (cmd_code_i),
    .hit_o   (hit)
  );

  act_track_state #(.ROW_W(ROW_W)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (hit.act),
    .pre_i  (hit.pre),
    .row_i  (row_i),
    .open_o (bank_open_o),
    .row_o  (open_row_o)
  );

  act_track_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (hit.act),
    .ref_i     (hit.refr),
    .rm_i      (hit.rm),
    .rm_en_i   (rm_enable_i),
    .ref_dec_i (ref_dec_i),
    .rm_dec_i  (rm_dec_i),
    .cnt_o     (act_count_o)
  );

  act_track_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (hit.refr | hit.rm),
    .block_i    (block_i),
    .unblock_i  (unblock_i),
    .pde_i      (hit.pde),
    .pdx_i      (hit.pdx),
    .blocked_o  (blocked_o),
    .sleeping_o (sleeping_o)
  );

  assign idle_o = ~req_pending_i;

  AST_NOCMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i && !block_i && !unblock_i) |=>
      ($stable(bank_open_o) && $stable(open_row_o) && $stable(act_count_o)
       && $stable(blocked_o) && $stable(sleeping_o))); // R12

endmodule

// File: tb/act_track_bank_tb.sv
module act_track_bank_tb;

  localparam int RW = 16;
  localparam int CW = 16;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [3:0]    cmd_code = '0;
  logic [RW-1:0] row = '0;
  logic          rm_en = 1'b0;
  logic [CW-1:0] ref_dec = '0;
  logic [CW-1:0] rm_dec = '0;
  logic          blk = 1'b0;
  logic          ublk = 1'b0;
  logic          pend = 1'b0;
  logic          bank_open, blocked, sleeping, idle;
  logic [RW-1:0] open_row;
  logic [CW-1:0] act_count;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_open, m_row, m_cnt, m_blk, m_slp;

  always #5 clk = ~clk;

  act_track_bank #(.ROW_W(RW), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
    .row_i(row), .rm_enable_i(rm_en), .ref_dec_i(ref_dec), .rm_dec_i(rm_dec),
    .block_i(blk), .unblock_i(ublk), .req_pending_i(pend),
    .bank_open_o(bank_open), .open_row_o(open_row), .act_count_o(act_count),
    .blocked_o(blocked), .sleeping_o(sleeping), .idle_o(idle)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all(input string tag);
    chk({tag, " open"},     int'(bank_open), m_open);
    chk({tag, " row"},      int'(open_row),  m_row);
    chk({tag, " count"},    int'(act_count), m_cnt);
    chk({tag, " blocked"},  int'(blocked),   m_blk);
    chk({tag, " sleeping"}, int'(sleeping),  m_slp);
  endtask

  // called just after a negedge; returns just after the next negedge
  task automatic step(input bit v, input int code, input int r, input bit b,
                      input bit u, input string tag);
    cmd_valid = v; cmd_code = 4'(code); row = RW'(r); blk = b; ublk = u;
    #1 chk({tag, " idle R11"}, int'(idle), pend ? 0 : 1);
    @(posedge clk);
    if (v) begin
      case (code)
        1: begin m_open = 1; m_row = r; if (m_cnt < CMAX) m_cnt++; end
        2, 3, 4: m_open = 0;
        5, 6: begin
          m_blk = 0; m_slp = 0;
          if (rm_en) m_cnt = (m_cnt > int'(ref_dec)) ? m_cnt - int'(ref_dec) : 0;
        end
        7, 8: begin
          m_blk = 0; m_slp = 0;
          if (rm_en) m_cnt = (m_cnt > int'(rm_dec)) ? m_cnt - int'(rm_dec) : 0;
        end
        9:  m_slp = 1;
        10: m_slp = 0;
        default: ;
      endcase
    end
    if (u) m_blk = 0;
    if (b) m_blk = 1;
    @(negedge clk);
    cmp_all(tag);
    cmd_valid = 1'b0; blk = 1'b0; ublk = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_open = 0; m_row = 0; m_cnt = 0; m_blk = 0; m_slp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all("R1 reset");

    // R2 / R4: activates and every precharge flavour
    step(1, 1, 16'h0123, 0, 0, "R2 act");
    step(1, 2, 0, 0, 0, "R4 pre");
    step(1, 1, 16'hBEEF, 0, 0, "R2 act2");
    step(1, 3, 0, 0, 0, "R4 prea");
    step(1, 1, 16'h0007, 0, 0, "R2 act3");
    step(1, 1, 16'hFFFF, 0, 0, "R2 act4");
    step(1, 4, 0, 0, 0, "R4 presb");
    step(1, 1, 16'h0042, 0, 0, "R2 act5");

    // R12: idle strobe, unused codes
    step(0, 1, 16'h1111, 0, 0, "R12 novalid");
    step(1, 0, 0, 0, 0, "R12 nop");
    for (int c = 11; c < 16; c++) step(1, c, 16'h2222, 0, 0, "R12 unused");

    // R7: refresh without management keeps the count
    rm_en = 1'b0; ref_dec = 16'd2; rm_dec = 16'd3;
    step(1, 5, 0, 0, 0, "R7 refab off");
    step(1, 7, 0, 0, 0, "R7 rmab off");

    // R5 / R6: reductions with floor
    rm_en = 1'b1;
    step(1, 5, 0, 0, 0, "R5 refab");      // 5 -> 3
    step(1, 6, 0, 0, 0, "R5 refsb");      // 3 -> 1
    step(1, 6, 0, 0, 0, "R5 floor");      // 1 -> 0
    for (int i = 0; i < 7; i++) step(1, 1, i, 0, 0, "R2 fill");
    step(1, 7, 0, 0, 0, "R6 rmab");       // 7 -> 4
    step(1, 8, 0, 0, 0, "R6 rmsb");       // 4 -> 1
    rm_dec = 16'd1;
    step(1, 8, 0, 0, 0, "R6 equal");      // 1 -> 0

    // R8 / R9 / R10: flags
    pend = 1'b1;
    step(0, 0, 0, 1, 0, "R9 block");
    step(1, 5, 0, 0, 0, "R8 ref clears");
    step(0, 0, 0, 1, 0, "R9 block2");
    step(1, 5, 0, 1, 0, "R9 block+ref");
    step(1, 8, 0, 1, 0, "R9 block+rm");
    step(0, 0, 0, 1, 1, "R9 block+unblock");
    step(0, 0, 0, 0, 1, "R9 unblock");
    step(1, 9, 0, 0, 0, "R10 pde");
    step(1, 10, 0, 0, 0, "R10 pdx");
    step(1, 9, 0, 0, 0, "R10 pde2");
    step(1, 7, 0, 1, 0, "R8 rm wakes");
    step(1, 9, 0, 0, 0, "R10 pde3");
    step(1, 6, 0, 0, 0, "R8 ref wakes");
    pend = 1'b0;
    step(0, 0, 0, 0, 0, "R11 idle");

    // R3: saturation
    for (int i = 0; i < CMAX + 4; i++) step(1, 1, i & 16'hFFFF, 0, 0, "R3 sat");
    rm_dec = 16'd100;
    step(1, 7, 0, 0, 0, "R6 from max");
    step(1, 1, 16'h0001, 0, 0, "R2 after max");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule